// File: doc/BRIEF.md
# Elapsed-Time Base and Encoder Bit-Clock Selector

This block keeps the time base for a data-gathering sequence. A 10 kHz reference enable advances a 24-bit binary count that restarts at the beginning of each sequence. A snapshot of the count is split into four 6-bit words. The encoder samples these as bi-level channels, so each stored frame carries the time elapsed since its sequence began.

The block also produces the encoder's external clock enable, which runs at twice the chosen bit rate. A 3-bit rate code picks the source. Codes 0 to 6 divide a master-clock enable by a power of two. Code 7 takes the reference count's divide-by-32 tap: 312.5 Hz, which gives a nominal rate of about 150 bit/s. All clocks are modelled as single-cycle enables in the `clk` domain.

Top module: `etb_rate_gen`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `enc_clk_en` is 0, the elapsed count and all stamp words are 0, and the active rate code is 0.
- R2: Each cycle with `ref_tick` high and `seq_start` low adds one to the 24-bit elapsed count. Without `ref_tick` the count holds.
- R3: `seq_start` clears the elapsed count and the master divider, taking priority over `ref_tick`. It also loads `rate_sel` at once as the active rate code, so the first pulse of a new sequence comes a full tap period after the start.
- R4: A `snap` pulse captures the elapsed count as it stood before that edge. The captured value appears on `stamp_words` one cycle later. Word k carries count bits [6k+5:6k]: word 0 holds the least significant bits and word 3 the most significant.
- R5: Without `snap`, `stamp_words` keeps its value while the elapsed count moves on.
- R6: With active code c in 0..6, `enc_clk_en` is high for one cycle right after the k-th `master_tick` since the sequence start whenever k is a multiple of 2^c. In all other cycles it is low.
- R7: With active code 7, `enc_clk_en` is high right after every 32nd `ref_tick` since the start, that is, after ticks that arrive while the count's low five bits are all ones. `master_tick` then has no effect.
- R8: A change of `rate_sel` without `seq_start` takes effect only at the edge where the currently active tap fires. That pulse belongs to the old rate, and later pulses follow the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | 10 kHz reference enable |
| master_tick | input | 1 | Master enable, twice the highest bit rate |
| seq_start | input | 1 | Start-of-sequence pulse |
| rate_sel | input | 3 | Rate code: 0..6 master/2^code, 7 reference/32 |
| snap | input | 1 | Capture the elapsed count into the holding register |
| enc_clk_en | output | 1 | Encoder clock enable at twice the bit rate |
| stamp_words | output | 24 | Four packed 6-bit timestamp words, word 0 in bits [5:0] |

## Verification
All outputs are registered. `enc_clk_en` and `stamp_words` respond one edge after the tick, `snap` or start that caused them. The bench drives each stimulus for exactly one cycle at a falling edge and reads the outputs at the next falling edge, so every check sees the result of exactly one edge. Idle cycles between ticks are checked for a low enable. The rate-switch scenario compares pulse positions against the old and new codes tick by tick.

// File: rtl/etb_pkg.sv
package etb_pkg;
  parameter int RATE_SEL_W = 3;
  localparam int NUM_CODES = 2 ** RATE_SEL_W;
  localparam int NUM_MASTER_TAPS = NUM_CODES - 1;
  localparam logic [RATE_SEL_W-1:0] CODE_REF_TAP = RATE_SEL_W'(NUM_CODES - 1);
endpackage

// File: rtl/etb_stamp_ctr.sv
module etb_stamp_ctr #(
  parameter int TS_W = 24,
  parameter int WORD_W = 6,
  parameter int REF_LOG2 = 5
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            ref_tick,
  input  logic                            seq_start,
  input  logic                            snap,
  output logic [TS_W-1:0]                 count,
  output logic                            ref_tap,
  output logic [TS_W/WORD_W-1:0][WORD_W-1:0] words
);
  localparam int NW = TS_W / WORD_W;

  logic [TS_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      hold  <= '0;
    end else begin
      if (seq_start)
        count <= '0;
      else if (ref_tick)
        count <= count + 1'b1;
      if (snap)
        hold <= count;
    end
  end

  // divide-by-2^REF_LOG2 tap of the reference chain
  assign ref_tap = ref_tick && !seq_start && (&count[REF_LOG2-1:0]);

  for (genvar k = 0; k < NW; k++) begin : g_word
    assign words[k] = hold[k*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/etb_master_div.sv
module etb_master_div #(
  parameter int NTAP = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            master_tick,
  input  logic            seq_start,
  output logic [NTAP-1:0] taps
);
  localparam int DW = (NTAP > 1) ? NTAP - 1 : 1;

  logic [DW-1:0] div;

  always_ff @(posedge clk) begin
    if (rst || seq_start)
      div <= '0;
    else if (master_tick)
      div <= div + 1'b1;
  end

  for (genvar n = 0; n < NTAP; n++) begin : g_tap
    if (n == 0) begin : g_full
      assign taps[n] = master_tick && !seq_start;
    end else begin : g_div
      assign taps[n] = master_tick && !seq_start && (&div[n-1:0]);
    end
  end
endmodule

// File: rtl/etb_rate_pick.sv
module etb_rate_pick
  import etb_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       seq_start,
  input  logic [RATE_SEL_W-1:0]      rate_sel,
  input  logic [NUM_MASTER_TAPS-1:0] master_taps,
  input  logic                       ref_tap,
  output logic [RATE_SEL_W-1:0]      act_sel,
  output logic                       enc_clk_en
);
  logic [NUM_CODES-1:0] all_taps;
  logic                 hit;

  assign all_taps = {ref_tap, master_taps};
  assign hit      = all_taps[act_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      act_sel    <= '0;
      enc_clk_en <= 1'b0;
    end else if (seq_start) begin
      act_sel    <= rate_sel;
      enc_clk_en <= 1'b0;
    end else begin
      enc_clk_en <= hit;
      if (hit)
        act_sel <= rate_sel;
    end
  end
endmodule

// File: rtl/etb_rate_gen.sv
module etb_rate_gen
  import etb_pkg::*;
#(
  parameter int TS_W = 24,
  parameter int WORD_W = 6,
  parameter int REF_LOG2 = 5
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               ref_tick,
  input  logic                               master_tick,
  input  logic                               seq_start,
  input  logic [RATE_SEL_W-1:0]              rate_sel,
  input  logic                               snap,
  output logic                               enc_clk_en,
  output logic [TS_W/WORD_W-1:0][WORD_W-1:0] stamp_words
);
  logic [TS_W-1:0]            ts_count;
  logic                       ref_tap;
  logic [NUM_MASTER_TAPS-1:0] master_taps;
  logic [RATE_SEL_W-1:0]      act_sel;

  etb_stamp_ctr #(.TS_W(TS_W), .WORD_W(WORD_W), .REF_LOG2(REF_LOG2)) u_stamp (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .seq_start(seq_start),
    .snap(snap), .count(ts_count), .ref_tap(ref_tap), .words(stamp_words)
  );

  etb_master_div #(.NTAP(NUM_MASTER_TAPS)) u_div (
    .clk(clk), .rst(rst), .master_tick(master_tick), .seq_start(seq_start),
    .taps(master_taps)
  );

  etb_rate_pick u_pick (
    .clk(clk), .rst(rst), .seq_start(seq_start), .rate_sel(rate_sel),
    .master_taps(master_taps), .ref_tap(ref_tap), .act_sel(act_sel),
    .enc_clk_en(enc_clk_en)
  );
endmodule

// File: rtl/etb_rate_gen_chk.sv
module etb_rate_gen_chk
  import etb_pkg::*;
#(
  parameter int TS_W = 24,
  parameter int WORD_W = 6
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               ref_tick,
  input logic                               seq_start,
  input logic                               snap,
  input logic                               enc_clk_en,
  input logic [TS_W/WORD_W-1:0][WORD_W-1:0] stamp_words,
  input logic [TS_W-1:0]                    ts_count,
  input logic [RATE_SEL_W-1:0]              act_sel
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!enc_clk_en && ts_count == '0 && stamp_words == '0 && act_sel == '0));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (ref_tick && !seq_start) |=> ts_count == TS_W'($past(ts_count) + 1'b1));

  assert_count_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!ref_tick && !seq_start) |=> $stable(ts_count));

  assert_start_clears_R3: assert property (@(posedge clk) disable iff (rst)
    seq_start |=> (ts_count == '0 && !enc_clk_en));

  assert_snap_capture_R4: assert property (@(posedge clk) disable iff (rst)
    snap |=> stamp_words == $past(ts_count));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
    !snap |=> $stable(stamp_words));

  assert_switch_at_tap_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_sel) |-> (enc_clk_en || $past(seq_start)));
endmodule

bind etb_rate_gen etb_rate_gen_chk #(.TS_W(TS_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .ref_tick(ref_tick), .seq_start(seq_start),
  .snap(snap), .enc_clk_en(enc_clk_en), .stamp_words(stamp_words),
  .ts_count(ts_count), .act_sel(act_sel)
);

// File: tb/sim_etb_rate_gen.sv
module sim_etb_rate_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b0, master_tick = 1'b0, seq_start = 1'b0, snap = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic enc_clk_en;
  logic [3:0][5:0] stamp_words;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  etb_rate_gen u0 (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .master_tick(master_tick),
    .seq_start(seq_start), .rate_sel(rate_sel), .snap(snap),
    .enc_clk_en(enc_clk_en), .stamp_words(stamp_words)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle of inputs at a falling edge, return at the next falling edge
  task automatic step(input bit rt, input bit mt, input bit ss, input bit sn);
    ref_tick = rt; master_tick = mt; seq_start = ss; snap = sn;
    @(posedge clk);
    @(negedge clk);
    ref_tick = 0; master_tick = 0; seq_start = 0; snap = 0;
  endtask

  task automatic check_stamp(input int v, input string req);
    step(0, 0, 0, 1);
    chk(stamp_words === 24'(v), req, stamp_words, v);
    chk(stamp_words[1] === 6'((v / 64) % 64), {req, " word1"}, stamp_words[1], (v / 64) % 64);
    chk(stamp_words[3] === 6'((v / 262144) % 64), {req, " word3"}, stamp_words[3], (v / 262144) % 64);
  endtask

  task automatic t_reset();
    chk(enc_clk_en === 1'b0, "R1 enc", enc_clk_en, 0);
    chk(stamp_words === '0, "R1 stamp", stamp_words, 0);
  endtask

  task automatic t_count();
    step(0, 0, 1, 0);
    for (int i = 0; i < 37; i++) step(1, 0, 0, 0);
    check_stamp(37, "R2/R4 count37");
    for (int i = 0; i < 5000; i++) step(1, 0, 0, 0);
    check_stamp(5037, "R2/R4 count5037");
  endtask

  task automatic t_hold();
    for (int i = 0; i < 10; i++) begin
      step(1, 0, 0, 0);
      chk(stamp_words === 24'd5037, "R5 hold", stamp_words, 5037);
    end
    check_stamp(5047, "R5 resnap");
  endtask

  task automatic t_clear();
    step(1, 0, 1, 0);
    check_stamp(0, "R3 clear over tick");
    rate_sel = 3'd2;
    step(0, 0, 1, 0);
    step(0, 1, 0, 0);
    step(0, 1, 0, 0);
    step(0, 0, 1, 0);
    for (int k = 1; k <= 4; k++) begin
      step(0, 1, 0, 0);
      chk(enc_clk_en === (k == 4), "R3 divider cleared", enc_clk_en, k == 4);
    end
  endtask

  task automatic t_master_rates();
    for (int c = 0; c < 7; c++) begin
      rate_sel = 3'(c);
      step(0, 0, 1, 0);
      for (int k = 1; k <= 2 * (1 << c) + 3; k++) begin
        step(0, 1, 0, 0);
        chk(enc_clk_en === ((k % (1 << c)) == 0), $sformatf("R6 code%0d tick%0d", c, k),
            enc_clk_en, (k % (1 << c)) == 0);
        step(0, 0, 0, 0);
        chk(enc_clk_en === 1'b0, "R6 idle", enc_clk_en, 0);
      end
    end
  endtask

  task automatic t_ref_rate();
    rate_sel = 3'd7;
    step(0, 0, 1, 0);
    for (int k = 1; k <= 70; k++) begin
      step(1, 1, 0, 0);
      chk(enc_clk_en === ((k % 32) == 0), $sformatf("R7 ref tick%0d", k), enc_clk_en, (k % 32) == 0);
    end
    step(0, 1, 0, 0);
    chk(enc_clk_en === 1'b0, "R7 master ignored", enc_clk_en, 0);
  endtask

  task automatic t_switch();
    bit exp;
    rate_sel = 3'd2;
    step(0, 0, 1, 0);
    for (int k = 1; k <= 10; k++) begin
      if (k == 2) rate_sel = 3'd0;
      if (k == 6) rate_sel = 3'd7;
      step(0, 1, 0, 0);
      exp = (k == 4) || (k == 5) || (k == 6);
      chk(enc_clk_en === exp, $sformatf("R8 switch tick%0d", k), enc_clk_en, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_hold();
    t_clear();
    t_master_rates();
    t_ref_rate();
    t_switch();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule